// File: doc/BRIEF.md
# SPI Register Access Slave

This block gives an external host read and write access to a bank of 16-bit internal registers over a four-wire serial link. It uses clock polarity 0 and phase 0. The host pulls the active-low select line low, sends one command byte, and then moves two data bytes. For a write the host sends both bytes. For a read the block returns both bytes. Data never travels in both directions in the same frame. The serial clock, data-in and select lines are treated as ordinary asynchronous inputs. Each one passes through a synchronizer into the single system clock domain. Edges of the serial clock are found by comparing successive synchronized samples, so the serial clock may run at no more than one quarter of the system clock.

On the register side the block presents a simple port. It has an address, a one-cycle read request whose data must be valid in the same cycle, and a one-cycle write strobe with its data. An input selects the behaviour of the serial data output while the select line is high: either the output is released (its enable is low) or it is held low.

The command byte is sent most significant bit first. Bit 7 set means read. Bit 6 is ignored. Bits 5:0 give the register address.

Top module: `spi_regport_slave`

## Requirements
- R1: Data in both directions is sent most significant bit first. The host samples the data output on each rising serial clock edge, and the block changes that output only after falling serial clock edges.
- R2: The first 8 bits after the select line falls form the command byte. Bit 7 set to 1 selects a read and 0 selects a write. Bits 5:0 are the register address, which appears on `reg_addr_o`.
- R3: Command bit 6 has no effect. The same frame with bit 6 set or clear gives the same strobes, the same address and the same data.
- R4: In a write frame, `reg_we_o` pulses for exactly one cycle once the 24th bit has been sampled. At that time `reg_wdata_o` holds the first data byte in bits 15:8 and the second data byte in bits 7:0.
- R5: If the select line rises before the 24th bit has been sampled, no write strobe is issued and the register keeps its old value.
- R6: Bits after the 24th in a frame are ignored. They cause no further write strobe and no read request, and the data output stays 0 for them.
- R7: In a read frame, `reg_re_o` pulses for exactly one cycle after the command byte, with the address on `reg_addr_o`. The value of `reg_rdata_i` captured in that cycle is shifted out on the next 16 bits, starting with the first falling edge after the command byte.
- R8: While the select line is low, the data output is 0 during the command byte, during all bits of a write frame, and after the 16 read data bits.
- R9: While the select line is low, `spi_miso_oe_o` is 1. While it is high, `spi_miso_oe_o` equals the inverse of `miso_float_en_i` and `spi_miso_o` is 0.
- R10: After reset, with the select line high, neither strobe is active and the output enable follows R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck_i | input | 1 | Serial clock from host (idle low) |
| spi_mosi_i | input | 1 | Serial data from host |
| spi_csn_i | input | 1 | Active-low frame select |
| spi_miso_o | output | 1 | Serial data to host |
| spi_miso_oe_o | output | 1 | Output enable for serial data pin |
| miso_float_en_i | input | 1 | 1: release data pin while idle, 0: drive it low |
| reg_addr_o | output | 6 | Register address from command byte |
| reg_wdata_o | output | 16 | Register write data |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_re_o | output | 1 | One-cycle read request |
| reg_rdata_i | input | 16 | Register read data, valid while `reg_re_o` is high |

## Verification
The bench targets four kinds of mistake. The first is a frame cut short by the select line: a design that commits on a partial frame would write a half-shifted value into the register. The second is a frame longer than 24 bits: a design that does not stop counting would issue a second strobe or keep shifting garbage onto the data line. The third is the ignored command bit 6: a design that decodes it as an address bit would write the wrong register. The fourth is the idle output mode: a design with the enable inverted or tied off would fight the bus or leave it floating. Read-back through the serial link also exposes bit-order mistakes and an off-by-one in the first output bit.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

  localparam int CMD_BITS  = 8;
  localparam int ADDR_BITS = 6;

  // Command byte decode: bit 7 selects read, bit 6 is ignored.
  function automatic logic cmd_is_read(input logic [CMD_BITS-1:0] cmd);
    return cmd[7];
  endfunction

  function automatic logic [ADDR_BITS-1:0] cmd_addr(input logic [CMD_BITS-1:0] cmd);
    return cmd[ADDR_BITS-1:0];
  endfunction

  // True while the bit index belongs to the read data window.
  function automatic logic in_data_window(input logic rd, input int cnt, input int frame_bits);
    return rd && (cnt >= CMD_BITS) && (cnt < frame_bits);
  endfunction

endpackage

// File: rtl/spi_sync_chain.sv
module spi_sync_chain #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{INIT}};
    else        chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import spi_regport_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int FRAME_BITS = CMD_BITS + DATA_W,
  parameter int CNT_W      = $clog2(FRAME_BITS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_act,
  input  logic                 sck_rise,
  input  logic                 mosi_s,
  output logic [CNT_W-1:0]     bit_cnt,
  output logic                 is_read,
  output logic [ADDR_BITS-1:0] addr_q,
  output logic [DATA_W-1:0]    wdata_q,
  output logic                 we_q,
  output logic                 re_q
);
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] shreg_next;
  logic              take_bit;
  logic              cmd_done;
  logic              frame_done;

  assign shreg_next = {shreg[DATA_W-2:0], mosi_s};
  assign take_bit   = cs_act && sck_rise && (bit_cnt < CNT_W'(FRAME_BITS));
  assign cmd_done   = take_bit && (bit_cnt == CNT_W'(CMD_BITS - 1));
  assign frame_done = take_bit && (bit_cnt == CNT_W'(FRAME_BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      is_read <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      shreg   <= '0;
      we_q    <= 1'b0;
      re_q    <= 1'b0;
    end else begin
      we_q <= 1'b0;
      re_q <= 1'b0;
      if (!cs_act) begin
        bit_cnt <= '0;
        is_read <= 1'b0;
      end else if (take_bit) begin
        shreg   <= shreg_next;
        bit_cnt <= bit_cnt + 1'b1;
        if (cmd_done) begin
          addr_q  <= cmd_addr(shreg_next[CMD_BITS-1:0]);
          is_read <= cmd_is_read(shreg_next[CMD_BITS-1:0]);
          re_q    <= cmd_is_read(shreg_next[CMD_BITS-1:0]);
        end
        if (frame_done && !is_read) begin
          we_q    <= 1'b1;
          wdata_q <= shreg_next;
        end
      end
    end
  end
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              sck_fall,
  input  logic              shift_en,
  output logic              miso_bit
);
  logic [DATA_W-1:0] tx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q     <= '0;
      miso_bit <= 1'b0;
    end else if (!cs_act) begin
      tx_q     <= '0;
      miso_bit <= 1'b0;
    end else begin
      if (load) tx_q <= load_data;
      if (sck_fall) begin
        if (shift_en) begin
          miso_bit <= tx_q[DATA_W-1];
          tx_q     <= {tx_q[DATA_W-2:0], 1'b0};
        end else begin
          miso_bit <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/spi_regport_slave.sv
module spi_regport_slave
  import spi_regport_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 spi_sck_i,
  input  logic                 spi_mosi_i,
  input  logic                 spi_csn_i,
  output logic                 spi_miso_o,
  output logic                 spi_miso_oe_o,
  input  logic                 miso_float_en_i,
  output logic [ADDR_BITS-1:0] reg_addr_o,
  output logic [DATA_W-1:0]    reg_wdata_o,
  output logic                 reg_we_o,
  output logic                 reg_re_o,
  input  logic [DATA_W-1:0]    reg_rdata_i
);
  localparam int FRAME_BITS = CMD_BITS + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int N_SYNC     = 3;
  localparam logic [N_SYNC-1:0] SYNC_INIT = 3'b100; // csn idles high

  logic [N_SYNC-1:0] raw_in;
  logic [N_SYNC-1:0] sync_lvl;
  assign raw_in = {spi_csn_i, spi_mosi_i, spi_sck_i};

  for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
    spi_sync_chain #(
      .STAGES(SYNC_STAGES),
      .INIT  (SYNC_INIT[g])
    ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_in[g]),
      .dout (sync_lvl[g])
    );
  end

  // Named internal events, also used by the checker.
  logic sck_s, mosi_s, cs_act;
  logic sck_prev;
  logic sck_rise, sck_fall;
  assign sck_s  = sync_lvl[0];
  assign mosi_s = sync_lvl[1];
  assign cs_act = ~sync_lvl[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev <= 1'b0;
    else        sck_prev <= sck_s;
  end
  assign sck_rise = sck_s & ~sck_prev;
  assign sck_fall = ~sck_s & sck_prev;

  logic [CNT_W-1:0] bit_cnt;
  logic             is_read;
  logic             shift_en;
  logic             miso_bit;

  spi_frame_rx #(
    .DATA_W    (DATA_W),
    .FRAME_BITS(FRAME_BITS),
    .CNT_W     (CNT_W)
  ) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_act  (cs_act),
    .sck_rise(sck_rise),
    .mosi_s  (mosi_s),
    .bit_cnt (bit_cnt),
    .is_read (is_read),
    .addr_q  (reg_addr_o),
    .wdata_q (reg_wdata_o),
    .we_q    (reg_we_o),
    .re_q    (reg_re_o)
  );

  assign shift_en = in_data_window(is_read, int'(bit_cnt), FRAME_BITS);

  spi_tx_shift #(.DATA_W(DATA_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_act   (cs_act),
    .load     (reg_re_o),
    .load_data(reg_rdata_i),
    .sck_fall (sck_fall),
    .shift_en (shift_en),
    .miso_bit (miso_bit)
  );

  assign spi_miso_o    = cs_act & miso_bit;
  assign spi_miso_oe_o = cs_act | ~miso_float_en_i;
endmodule

// File: rtl/spi_regport_checker.sv
module spi_regport_checker #(
  parameter int FRAME_BITS = 24,
  parameter int CNT_W      = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_act,
  input logic             is_read,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             reg_we,
  input logic             reg_re,
  input logic             miso,
  input logic             miso_oe,
  input logic             float_en
);
  a_r4_we_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);
  a_r7_re_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> !reg_re);
  a_r2_we_re_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_re));
  a_r5_we_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $past(cs_act));
  a_r9_idle_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |-> (miso_oe == !float_en));
  a_r9_active_enable: assert property (@(posedge clk) disable iff (!rst_n)
    cs_act |-> miso_oe);
  a_r9_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |-> !miso);
  a_r8_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && !is_read) |-> !miso);
  a_r6_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(FRAME_BITS));
endmodule

bind spi_regport_slave spi_regport_checker #(
  .FRAME_BITS(FRAME_BITS),
  .CNT_W     (CNT_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cs_act  (cs_act),
  .is_read (is_read),
  .bit_cnt (bit_cnt),
  .reg_we  (reg_we_o),
  .reg_re  (reg_re_o),
  .miso    (spi_miso_o),
  .miso_oe (spi_miso_oe_o),
  .float_en(miso_float_en_i)
);

// File: tb/spi_regport_slave_test.sv
module spi_regport_slave_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck = 1'b0, mosi = 1'b0, csn = 1'b1;
  logic        miso, miso_oe;
  logic        float_en = 1'b1;
  logic [5:0]  raddr;
  logic [15:0] wdata, rdata;
  logic        we, re;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  spi_regport_slave uut (
    .clk(clk), .rst_n(rst_n), .spi_sck_i(sck), .spi_mosi_i(mosi), .spi_csn_i(csn),
    .spi_miso_o(miso), .spi_miso_oe_o(miso_oe), .miso_float_en_i(float_en),
    .reg_addr_o(raddr), .reg_wdata_o(wdata), .reg_we_o(we), .reg_re_o(re),
    .reg_rdata_i(rdata)
  );

  // Register bank attached to the port, plus an independent expectation array.
  logic [15:0] bank [64];
  logic [15:0] expv [64];
  assign rdata = bank[raddr];

  // Expected strobe queues, checked on every clock.
  logic [21:0] wq [$];
  logic [5:0]  rq [$];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (we) begin
        if (wq.size() == 0) check(1'b0, "R4/R5/R6 unexpected write strobe", {10'd0, raddr, wdata}, 32'd0);
        else begin
          logic [21:0] e;
          e = wq.pop_front();
          check({raddr, wdata} == e, "R4 write addr/data", {10'd0, raddr, wdata}, {10'd0, e});
        end
        bank[raddr] = wdata;
      end
      if (re) begin
        if (rq.size() == 0) check(1'b0, "R7/R6 unexpected read request", {26'd0, raddr}, 32'd0);
        else begin
          logic [5:0] ea;
          ea = rq.pop_front();
          check(raddr == ea, "R7 read address", {26'd0, raddr}, {26'd0, ea});
        end
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One frame: drive nbits from the top of obits, capture data line at each rising edge.
  task automatic frame(input logic [31:0] obits, input int nbits, output logic [31:0] ibits);
    bit oe_ok = 1;
    ibits = '0;
    csn = 1'b0;
    wait_clk(4);
    for (int i = 0; i < nbits; i++) begin
      mosi = obits[31-i];
      wait_clk(4);
      sck = 1'b1;
      ibits[31-i] = miso;
      if (miso_oe !== 1'b1) oe_ok = 0;
      wait_clk(4);
      sck = 1'b0;
    end
    wait_clk(4);
    csn = 1'b1;
    wait_clk(8);
    check(oe_ok, "R9 enable high during frame", {31'd0, oe_ok}, 32'd1);
    check(wq.size() == 0 && rq.size() == 0, "R4/R7 strobe count per frame",
          wq.size() + rq.size(), 32'd0);
  endtask

  task automatic do_write(input logic [7:0] cmd, input logic [15:0] d, input int nbits, input logic [7:0] extra);
    logic [31:0] ib;
    if (nbits >= 24) begin
      wq.push_back({cmd[5:0], d});
      expv[cmd[5:0]] = d;
    end
    frame({cmd, d, extra}, nbits, ib);
    check(ib == 32'd0, "R8 data line low during write frame", ib, 32'd0);
  endtask

  task automatic do_read(input logic [7:0] cmd, input int nbits, input string req);
    logic [31:0] ib;
    rq.push_back(cmd[5:0]);
    frame({cmd, 24'd0}, nbits, ib);
    check(ib[31:24] == 8'd0, "R8 data line low during command", {24'd0, ib[31:24]}, 32'd0);
    check(ib[23:8] == expv[cmd[5:0]], req, {16'd0, ib[23:8]}, {16'd0, expv[cmd[5:0]]});
    if (nbits > 24)
      check(ib[7:0] == 8'd0, "R6 data line low after read data", {24'd0, ib[7:0]}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    if (!finished) begin
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      bank[i] = 16'h1000 + 16'(i);
      expv[i] = 16'h1000 + 16'(i);
    end
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);

    // R10 / R9: reset state
    check(miso_oe == 1'b0, "R10 enable released after reset", {31'd0, miso_oe}, 32'd0);
    check(miso == 1'b0 && we == 1'b0 && re == 1'b0, "R10 outputs idle after reset",
          {29'd0, miso, we, re}, 32'd0);
    float_en = 1'b0;
    wait_clk(2);
    check(miso_oe == 1'b1 && miso == 1'b0, "R9 idle driven low", {30'd0, miso_oe, miso}, 32'd2);
    float_en = 1'b1;
    wait_clk(2);
    check(miso_oe == 1'b0, "R9 idle released", {31'd0, miso_oe}, 32'd0);

    // R2 / R4: writes at boundaries and varied patterns
    do_write(8'h00, 16'hA5C3, 24, 8'h00);
    do_write(8'h3F, 16'h8001, 24, 8'h00);
    do_write(8'h15, 16'hFFFF, 24, 8'h00);
    do_write(8'h2A, 16'h0000, 24, 8'h00);

    // R1 / R7: read back, plus an untouched register
    do_read(8'h80, 24, "R1 read data addr 0");
    do_read(8'hBF, 24, "R1 read data addr 63");
    do_read(8'h95, 24, "R7 read data addr 21");
    do_read(8'hAA, 24, "R7 read data addr 42");
    do_read(8'h85, 24, "R7 read untouched addr 5");

    // R3: ignored command bit 6
    do_write(8'h47, 16'h1234, 24, 8'h00);
    do_read(8'hC7, 24, "R3 bit6 ignored addr 7");

    // R5: aborted write after 16 bits and after 23 bits
    do_write(8'h09, 16'hDEAD, 16, 8'h00);
    do_write(8'h09, 16'hBEEF, 23, 8'h00);
    do_read(8'h89, 24, "R5 aborted write leaves value");

    // R6: overlong frames
    do_write(8'h0A, 16'hBEEF, 32, 8'h77);
    do_read(8'h8A, 32, "R6 overlong write committed once");

    // R9: reads with idle drive-low mode
    float_en = 1'b0;
    do_write(8'h30, 16'h5AA5, 24, 8'h00);
    do_read(8'hB0, 24, "R1 read in drive-low mode");
    check(miso_oe == 1'b1 && miso == 1'b0, "R9 idle low after frame", {30'd0, miso_oe, miso}, 32'd2);
    float_en = 1'b1;
    wait_clk(2);
    check(miso_oe == 1'b0, "R9 released after frame", {31'd0, miso_oe}, 32'd0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule